// File: doc/BRIEF.md
# Preemptive Flash Operation Scheduler

This block sits between the request queues of one flash plane and the command port of the flash chip. It takes three queue heads (reads, writes that become page programs, and erases) and turns them into a stream of single-cycle commands: issue an operation, suspend the running operation, or resume a suspended one. Reads come first. A read that arrives while a program or erase is running causes that operation to be suspended. A write can push aside a running erase, but only while enough clean space remains. Suspended operations are kept on a two-entry stack, so a program that interrupted an erase can itself be interrupted by a read.

The chip reports two events. One pulse says that the running operation has completed. A second pulse confirms a requested suspension. The scheduler tracks which operation is active and how many are parked, so it never has more than one suspension in flight. When the accumulated write-delay overhead rises above a programmable limit, the block drops all preemption and serves writes ahead of reads. It returns to normal behaviour once the overhead falls back to the limit or below.

Top module: `flash_preempt_sched`

## Requirements
- R1: When the chip is idle, overhead is at or below the limit, and a read and a write are both pending, the read is issued first. Command kind ISSUE=0, SUSPEND=1, RESUME=2. Operation READ=1, PROG=2, ERASE=3.
- R2: A read that is pending while a program or erase runs produces a SUSPEND carrying the running operation. The read is issued only after the chip acknowledges the suspension.
- R3: A write never suspends a program or a read. A SUSPEND of PROG happens only when a read is pending.
- R4: Suspensions nest up to two deep: an erase suspended by a write, then the program suspended by a read.
- R5: After the operation that did the preempting completes, pending reads are issued first. Pending writes follow while the parked operation on top is an erase. RESUME is issued only when nothing eligible is pending.
- R6: A write suspends a running erase only while clean_lvl_i is strictly greater than clean_wm_i.
- R7: While wr_ovh_i > ovh_thr_i, no SUSPEND is issued and an idle chip takes a pending write before a pending read. Preemption comes back once wr_ovh_i <= ovh_thr_i.
- R8: No SUSPEND is issued while an earlier suspension is still waiting for its acknowledgement.
- R9: Resumes come out in last-suspended, first-resumed order. A parked program is resumed before the erase underneath it.
- R10: At most one program is parked. While a program is parked, a new pending write is not issued; the parked program is resumed instead.
- R11: After reset no operation is active, nothing is parked, and no command is produced during reset. The first command after reset with a read pending is ISSUE READ.
- R12: If the chip reports completion instead of a suspend acknowledgement, the operation is treated as finished. It is not parked and is never resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_valid_i | input | 1 | Read queue head valid |
| rd_ready_o | output | 1 | Read queue pop (read issued) |
| wr_valid_i | input | 1 | Write queue head valid |
| wr_ready_o | output | 1 | Write queue pop (program issued) |
| er_valid_i | input | 1 | Erase queue head valid |
| er_ready_o | output | 1 | Erase queue pop (erase issued) |
| chip_done_i | input | 1 | Running operation completed |
| chip_susp_ack_i | input | 1 | Requested suspension confirmed |
| clean_lvl_i | input | LVL_W | Current clean-space level |
| clean_wm_i | input | LVL_W | Watermark gating write-over-erase preemption |
| wr_ovh_i | input | LVL_W | Accumulated write-delay overhead |
| ovh_thr_i | input | LVL_W | Overhead limit that disables preemption |
| cmd_valid_o | output | 1 | Command strobe, one cycle |
| cmd_kind_o | output | 2 | ISSUE=0, SUSPEND=1, RESUME=2 |
| cmd_op_o | output | 2 | READ=1, PROG=2, ERASE=3 |

## Verification
The bench builds the block with its defaults: LVL_W=8 and a stack depth of two. That depth is exactly the nesting limit, so a single scenario reaches the full-stack case: erase parked, then program parked, then unwinding in reverse order. The 8-bit levels let the bench put the clean level on either side of the watermark and the overhead on either side of its limit. This exercises the preemption gate in both states and shows preemption returning after throttling.

// File: rtl/flash_sched_pkg.sv
package flash_sched_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CK_ISSUE   = 2'd0,
    CK_SUSPEND = 2'd1,
    CK_RESUME  = 2'd2
  } cmd_kind_e;

  typedef enum logic [2:0] {
    AC_NONE,
    AC_RD,
    AC_WR,
    AC_ER,
    AC_SUSP_RD,
    AC_SUSP_WR,
    AC_RESUME
  } action_e;

endpackage

// File: rtl/flash_susp_stack.sv
module flash_susp_stack
  import flash_sched_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  op_e              op_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o,
  output op_e              top_o
);

  logic [CNT_W-1:0] cnt_q;
  op_e              mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= OP_NONE;
      else if (push_i && cnt_q == CNT_W'(g)) mem_q[g] <= op_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (push_i && !pop_i && cnt_q < CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !push_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    top_o = OP_NONE;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) top_o = mem_q[i];
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/flash_sched_arbiter.sv
module flash_sched_arbiter
  import flash_sched_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             rd_v_i,
  input  logic             wr_v_i,
  input  logic             er_v_i,
  input  op_e              active_i,
  input  logic             susp_wait_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] stk_cnt_i,
  input  op_e              stk_top_i,
  input  logic             throttle_i,
  input  logic             space_ok_i,
  output action_e          act_o
);

  logic stk_empty, stk_full, wr_ok_idle, preemptible;

  assign stk_empty   = (stk_cnt_i == '0);
  assign stk_full    = (stk_cnt_i >= CNT_W'(DEPTH));
  // a new program may start only if no program is parked above
  assign wr_ok_idle  = wr_v_i && (stk_empty || stk_top_i == OP_ERASE);
  assign preemptible = (active_i == OP_PROG) || (active_i == OP_ERASE);

  always_comb begin
    act_o = AC_NONE;
    if (susp_wait_i || done_i) begin
      act_o = AC_NONE;
    end else if (active_i == OP_NONE) begin
      if (!throttle_i) begin
        if (rd_v_i)          act_o = AC_RD;
        else if (wr_ok_idle) act_o = AC_WR;
        else if (!stk_empty) act_o = AC_RESUME;
        else if (er_v_i)     act_o = AC_ER;
      end else begin
        if (wr_ok_idle)      act_o = AC_WR;
        else if (rd_v_i)     act_o = AC_RD;
        else if (!stk_empty) act_o = AC_RESUME;
        else if (er_v_i)     act_o = AC_ER;
      end
    end else if (!throttle_i && !stk_full) begin
      if (rd_v_i && preemptible)
        act_o = AC_SUSP_RD;
      else if (!rd_v_i && wr_v_i && active_i == OP_ERASE && space_ok_i)
        act_o = AC_SUSP_WR;
    end
  end

endmodule

// File: rtl/flash_preempt_sched.sv
module flash_preempt_sched
  import flash_sched_pkg::*;
#(
  parameter int LVL_W       = 8,
  parameter int STACK_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_valid_i,
  output logic             rd_ready_o,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic             er_valid_i,
  output logic             er_ready_o,
  input  logic             chip_done_i,
  input  logic             chip_susp_ack_i,
  input  logic [LVL_W-1:0] clean_lvl_i,
  input  logic [LVL_W-1:0] clean_wm_i,
  input  logic [LVL_W-1:0] wr_ovh_i,
  input  logic [LVL_W-1:0] ovh_thr_i,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_kind_o,
  output logic [1:0]       cmd_op_o
);

  localparam int STK_CW = $clog2(STACK_DEPTH + 1);

  op_e              active_q;
  logic             susp_wait_q;
  logic [STK_CW-1:0] stk_cnt;
  op_e              stk_top;
  action_e          act;
  logic             throttle, space_ok, ack_fire, stk_push, stk_pop;
  logic             cmd_valid_q;
  cmd_kind_e        cmd_kind_q;
  op_e              cmd_op_q;

  assign throttle = wr_ovh_i > ovh_thr_i;
  assign space_ok = clean_lvl_i > clean_wm_i;
  assign ack_fire = chip_susp_ack_i && susp_wait_q && !chip_done_i;
  assign stk_push = ack_fire;
  assign stk_pop  = (act == AC_RESUME);

  flash_sched_arbiter #(
    .DEPTH (STACK_DEPTH),
    .CNT_W (STK_CW)
  ) u_arb (
    .rd_v_i      (rd_valid_i),
    .wr_v_i      (wr_valid_i),
    .er_v_i      (er_valid_i),
    .active_i    (active_q),
    .susp_wait_i (susp_wait_q),
    .done_i      (chip_done_i),
    .stk_cnt_i   (stk_cnt),
    .stk_top_i   (stk_top),
    .throttle_i  (throttle),
    .space_ok_i  (space_ok),
    .act_o       (act)
  );

  flash_susp_stack #(
    .DEPTH (STACK_DEPTH),
    .CNT_W (STK_CW)
  ) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (stk_push),
    .op_i   (active_q),
    .pop_i  (stk_pop),
    .cnt_o  (stk_cnt),
    .top_o  (stk_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= OP_NONE;
      susp_wait_q <= 1'b0;
    end else if (chip_done_i) begin
      active_q    <= OP_NONE;
      susp_wait_q <= 1'b0;
    end else if (ack_fire) begin
      active_q    <= OP_NONE;
      susp_wait_q <= 1'b0;
    end else begin
      unique case (act)
        AC_RD:                  active_q    <= OP_READ;
        AC_WR:                  active_q    <= OP_PROG;
        AC_ER:                  active_q    <= OP_ERASE;
        AC_SUSP_RD, AC_SUSP_WR: susp_wait_q <= 1'b1;
        AC_RESUME:              active_q    <= stk_top;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_q <= 1'b0;
      cmd_kind_q  <= CK_ISSUE;
      cmd_op_q    <= OP_NONE;
    end else begin
      cmd_valid_q <= (act != AC_NONE);
      unique case (act)
        AC_RD:      begin cmd_kind_q <= CK_ISSUE;   cmd_op_q <= OP_READ;  end
        AC_WR:      begin cmd_kind_q <= CK_ISSUE;   cmd_op_q <= OP_PROG;  end
        AC_ER:      begin cmd_kind_q <= CK_ISSUE;   cmd_op_q <= OP_ERASE; end
        AC_SUSP_RD,
        AC_SUSP_WR: begin cmd_kind_q <= CK_SUSPEND; cmd_op_q <= active_q; end
        AC_RESUME:  begin cmd_kind_q <= CK_RESUME;  cmd_op_q <= stk_top;  end
        default: ;
      endcase
    end
  end

  assign rd_ready_o  = (act == AC_RD);
  assign wr_ready_o  = (act == AC_WR);
  assign er_ready_o  = (act == AC_ER);
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_kind_o  = cmd_kind_q;
  assign cmd_op_o    = cmd_op_q;

endmodule

// File: rtl/flash_preempt_sched_chk.sv
module flash_preempt_sched_chk #(
  parameter int LVL_W       = 8,
  parameter int STACK_DEPTH = 2,
  parameter int STK_CW      = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_valid_i,
  input logic              chip_done_i,
  input logic [LVL_W-1:0]  clean_lvl_i,
  input logic [LVL_W-1:0]  clean_wm_i,
  input logic [LVL_W-1:0]  wr_ovh_i,
  input logic [LVL_W-1:0]  ovh_thr_i,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_kind_o,
  input logic [1:0]        cmd_op_o,
  input logic              susp_wait_q,
  input logic [STK_CW-1:0] stk_cnt
);

  logic is_susp, is_resume, is_issue;
  assign is_susp   = cmd_valid_o && cmd_kind_o == 2'd1;
  assign is_resume = cmd_valid_o && cmd_kind_o == 2'd2;
  assign is_issue  = cmd_valid_o && cmd_kind_o == 2'd0;

  AST_READ_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_issue && cmd_op_o == 2'd2) |-> $past(!rd_valid_i || wr_ovh_i > ovh_thr_i)); // R1

  AST_PROG_SUSP_BY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_susp && cmd_op_o == 2'd2) |-> $past(rd_valid_i)); // R3

  AST_NEVER_SUSP_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_susp |-> cmd_op_o != 2'd1); // R3

  AST_NEST_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_susp |-> $past(stk_cnt < STK_CW'(STACK_DEPTH))); // R4

  AST_RESUME_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_resume |-> $past(!rd_valid_i)); // R5

  AST_SPACE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_susp && cmd_op_o == 2'd3 && $past(!rd_valid_i)) |-> $past(clean_lvl_i > clean_wm_i)); // R6

  AST_THROTTLE_NO_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_susp |-> $past(wr_ovh_i <= ovh_thr_i)); // R7

  AST_ONE_SUSP_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_susp |-> !$past(susp_wait_q)); // R8

  AST_NO_SUSP_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_susp |-> !$past(chip_done_i)); // R12

endmodule

bind flash_preempt_sched flash_preempt_sched_chk #(
  .LVL_W       (LVL_W),
  .STACK_DEPTH (STACK_DEPTH),
  .STK_CW      (STK_CW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_valid_i  (rd_valid_i),
  .chip_done_i (chip_done_i),
  .clean_lvl_i (clean_lvl_i),
  .clean_wm_i  (clean_wm_i),
  .wr_ovh_i    (wr_ovh_i),
  .ovh_thr_i   (ovh_thr_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_kind_o  (cmd_kind_o),
  .cmd_op_o    (cmd_op_o),
  .susp_wait_q (susp_wait_q),
  .stk_cnt     (stk_cnt)
);

// File: tb/flash_preempt_sched_tb.sv
module flash_preempt_sched_tb;

  localparam int K_ISS = 0, K_SUS = 1, K_RES = 2;
  localparam int O_RD = 1, O_PG = 2, O_ER = 3;

  logic       clk, rst_n;
  logic       rd_valid, wr_valid, er_valid, done, ack;
  logic       rd_ready, wr_ready, er_ready;
  logic [7:0] clean_lvl, clean_wm, ovh, ovh_thr;
  logic       cmd_valid;
  logic [1:0] cmd_kind, cmd_op;

  int n_checks = 0;
  int n_fails  = 0;

  flash_preempt_sched u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .rd_valid_i      (rd_valid),
    .rd_ready_o      (rd_ready),
    .wr_valid_i      (wr_valid),
    .wr_ready_o      (wr_ready),
    .er_valid_i      (er_valid),
    .er_ready_o      (er_ready),
    .chip_done_i     (done),
    .chip_susp_ack_i (ack),
    .clean_lvl_i     (clean_lvl),
    .clean_wm_i      (clean_wm),
    .wr_ovh_i        (ovh),
    .ovh_thr_i       (ovh_thr),
    .cmd_valid_o     (cmd_valid),
    .cmd_kind_o      (cmd_kind),
    .cmd_op_o        (cmd_op)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic wait_cmd(input int k, input int o, input string tag);
    bit seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (cmd_valid) seen = 1;
    end
    n_checks++;
    if (!seen) begin
      n_fails++;
      $display("FAIL %s: no command, expected kind=%0d op=%0d", tag, k, o);
    end else if (int'(cmd_kind) != k || int'(cmd_op) != o) begin
      n_fails++;
      $display("FAIL %s: kind=%0d op=%0d, expected kind=%0d op=%0d",
               tag, cmd_kind, cmd_op, k, o);
    end
  endtask

  task automatic check_quiet(input int n, input string tag);
    int bad = 0;
    int bk = 0;
    int bo = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmd_valid && bad == 0) begin
        bad = 1;
        bk = int'(cmd_kind);
        bo = int'(cmd_op);
      end
    end
    n_checks++;
    if (bad != 0) begin
      n_fails++;
      $display("FAIL %s: command kind=%0d op=%0d, expected none", tag, bk, bo);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset();
    rd_valid = 1'b1;
    repeat (3) @(negedge clk);
    n_checks++;
    if (cmd_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R11: cmd_valid=%0b during reset, expected 0", cmd_valid);
    end
    rst_n = 1'b1;
    wait_cmd(K_ISS, O_RD, "R11 first command");
    rd_valid = 1'b0;
    pulse_done();
    check_quiet(3, "R11 idle after read");
  endtask

  task automatic t_read_priority();
    @(negedge clk);
    rd_valid = 1'b1; wr_valid = 1'b1;
    wait_cmd(K_ISS, O_RD, "R1 read before write");
    rd_valid = 1'b0;
    pulse_done();
    wait_cmd(K_ISS, O_PG, "R1 write after read");
    wr_valid = 1'b0;
    pulse_done();
  endtask

  task automatic t_read_preempt_prog();
    @(negedge clk); wr_valid = 1'b1;
    wait_cmd(K_ISS, O_PG, "R2 program start");
    wr_valid = 1'b0;
    rd_valid = 1'b1;
    wait_cmd(K_SUS, O_PG, "R2 suspend program");
    check_quiet(4, "R8 no second suspend before ack");
    pulse_ack();
    wait_cmd(K_ISS, O_RD, "R2 read after ack");
    rd_valid = 1'b0;
    pulse_done();
    wait_cmd(K_RES, O_PG, "R5 resume when idle");
    pulse_done();
  endtask

  task automatic t_nested();
    clean_lvl = 8'd200; clean_wm = 8'd100;
    @(negedge clk); er_valid = 1'b1;
    wait_cmd(K_ISS, O_ER, "R4 erase start");
    er_valid = 1'b0;
    wr_valid = 1'b1;
    wait_cmd(K_SUS, O_ER, "R6 write suspends erase");
    pulse_ack();
    wait_cmd(K_ISS, O_PG, "R5 write over parked erase");
    wr_valid = 1'b0;
    rd_valid = 1'b1;
    wait_cmd(K_SUS, O_PG, "R4 nested suspend");
    pulse_ack();
    wait_cmd(K_ISS, O_RD, "R4 read at depth two");
    rd_valid = 1'b0;
    pulse_done();
    wait_cmd(K_RES, O_PG, "R9 program resumed first");
    pulse_done();
    wait_cmd(K_RES, O_ER, "R9 erase resumed last");
    pulse_done();
    check_quiet(3, "R9 stack drained");
  endtask

  task automatic t_low_space();
    clean_lvl = 8'd100; clean_wm = 8'd100;
    @(negedge clk); er_valid = 1'b1;
    wait_cmd(K_ISS, O_ER, "R6 erase start");
    er_valid = 1'b0;
    wr_valid = 1'b1;
    check_quiet(5, "R6 no preempt at watermark");
    pulse_done();
    wait_cmd(K_ISS, O_PG, "R6 write after erase");
    wr_valid = 1'b0;
    pulse_done();
    clean_lvl = 8'd200;
  endtask

  task automatic t_throttle();
    ovh = 8'd150; ovh_thr = 8'd100;
    @(negedge clk); wr_valid = 1'b1;
    wait_cmd(K_ISS, O_PG, "R7 program start");
    wr_valid = 1'b0;
    rd_valid = 1'b1;
    check_quiet(5, "R7 no suspend while throttled");
    pulse_done();
    wait_cmd(K_ISS, O_RD, "R7 read after program");
    rd_valid = 1'b0;
    pulse_done();
    @(negedge clk);
    rd_valid = 1'b1; wr_valid = 1'b1;
    wait_cmd(K_ISS, O_PG, "R7 write before read");
    wr_valid = 1'b0;
    pulse_done();
    wait_cmd(K_ISS, O_RD, "R7 read follows");
    rd_valid = 1'b0;
    pulse_done();
    ovh = 8'd100;
    @(negedge clk); wr_valid = 1'b1;
    wait_cmd(K_ISS, O_PG, "R7 program after release");
    wr_valid = 1'b0;
    rd_valid = 1'b1;
    wait_cmd(K_SUS, O_PG, "R7 preemption restored");
    pulse_ack();
    wait_cmd(K_ISS, O_RD, "R7 read after restore");
    rd_valid = 1'b0;
    pulse_done();
    wait_cmd(K_RES, O_PG, "R7 resume after restore");
    pulse_done();
    ovh = 8'd0;
  endtask

  task automatic t_single_prog_parked();
    @(negedge clk); wr_valid = 1'b1;
    wait_cmd(K_ISS, O_PG, "R10 first program");
    rd_valid = 1'b1;
    wait_cmd(K_SUS, O_PG, "R10 suspend program");
    pulse_ack();
    wait_cmd(K_ISS, O_RD, "R10 read");
    rd_valid = 1'b0;
    pulse_done();
    wait_cmd(K_RES, O_PG, "R10 resume not new program");
    pulse_done();
    wait_cmd(K_ISS, O_PG, "R10 second program after resume");
    wr_valid = 1'b0;
    pulse_done();
  endtask

  task automatic t_done_instead_of_ack();
    @(negedge clk); wr_valid = 1'b1;
    wait_cmd(K_ISS, O_PG, "R12 program start");
    wr_valid = 1'b0;
    rd_valid = 1'b1;
    wait_cmd(K_SUS, O_PG, "R12 suspend requested");
    pulse_done();
    wait_cmd(K_ISS, O_RD, "R12 read after completion");
    rd_valid = 1'b0;
    pulse_done();
    check_quiet(5, "R12 nothing parked to resume");
  endtask

  initial begin
    rst_n = 1'b0;
    rd_valid = 1'b0; wr_valid = 1'b0; er_valid = 1'b0;
    done = 1'b0; ack = 1'b0;
    clean_lvl = 8'd200; clean_wm = 8'd100;
    ovh = 8'd0; ovh_thr = 8'd100;
    t_reset();
    t_read_priority();
    t_read_preempt_prog();
    t_nested();
    t_low_space();
    t_throttle();
    t_single_prog_parked();
    t_done_instead_of_ack();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule